// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Validity Status

This block holds the interrupt status of a real-time clock. Three sticky event flags (periodic, alarm, update-ended) are set by single-cycle pulses from the divider chain, the alarm comparator and the update sequencer. Each has a matching enable input. A summary bit is the OR of every flag whose enable is on. That summary drives an active-low interrupt pin. Software reads the flag register to learn which events happened. The same read clears all three flags.

A second register reports whether time and memory contents can be trusted. Its top bit is a validity bit. Only the battery-domain reset clears it, and only a read of this register sets it. The register also holds a writable day-of-month field that keeps its value across main-supply resets. The main-supply reset clears the flags only.

Top module: `rtc_irq_status`

## Requirements
- R1: In a flag-register read, bit 7 is 1 exactly when at least one of the pairs (bit 6 with periodic enable), (bit 5 with alarm enable) or (bit 4 with update enable) is 1 in both members.
- R2: `irq_n` is 0 exactly when at least one flag is set with its enable on, and 1 otherwise.
- R3: A pulse on `tap_edge`, `alarm_hit` or `update_done` sets its flag from the next cycle, whatever the state of its enable. The flag appears in flag-register bit 6, 5 or 4.
- R4: A flag-register read returns the flags as they were before the read. From the next cycle all flags are 0 unless an event arrived in the read cycle, and `irq_n` then returns to 1.
- R5: An event pulse in the same cycle as a clearing read of the flag register is kept and shows in the next read.
- R6: Flag-register bits 3..0 always read 0. A write to the flag-register address changes nothing.
- R7: `main_rst_n` low clears every flag and sets `irq_n` to 1. It leaves the validity bit and the day field unchanged.
- R8: The validity bit, at bit 7 of the validity register, becomes 1 after any read of that register and stays 1 until `bat_rst_n` goes low. The read that sets it returns the value it had before.
- R9: Validity-register bit 6 always reads 0. Bits 5..0 return the day field, and a write to the validity address loads that field from `wr_data`.
- R10: `bat_rst_n` low clears the validity bit and the day field.
- R11: `rd_data` is 0 when `rd_stb` is 0 or when `rd_addr` selects neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| main_rst_n | input | 1 | Main-supply reset, asynchronous, active low |
| bat_rst_n | input | 1 | Battery-domain reset, asynchronous, active low |
| tap_edge | input | 1 | Periodic divider-tap edge pulse |
| alarm_hit | input | 1 | Alarm-match pulse |
| update_done | input | 1 | Update-ended pulse |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read address (flag register 2, validity register 3 by default) |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DAY_W | Write data for the day field |
| rd_data | output | 8 | Read data, combinational from current state while `rd_stb` is high |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that each read or write strobe lasts one clock cycle per access. They also assume that event pulses and enables are stable around the rising edge, so each pulse sets its flag exactly once. The stimulus drives every input at the falling edge. Event pulses are sparse, and reads, writes and addresses are drawn at random each cycle. The directed cases line up an event with a clearing read, a write to the flag address, and each reset taken alone.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

   localparam int unsigned NUM_SRC  = 3;
   localparam int unsigned SRC_PER  = 0;
   localparam int unsigned SRC_ALM  = 1;
   localparam int unsigned SRC_UPD  = 2;
   localparam int unsigned FIELD_W  = 6;

   typedef struct packed {
      logic       summary;
      logic       per;
      logic       alm;
      logic       upd;
      logic [3:0] zero;
   } flag_byte_t;

   typedef struct packed {
      logic               valid;
      logic               zero;
      logic [FIELD_W-1:0] day;
   } valid_byte_t;

endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else begin
         // a set in the clearing cycle wins so the event is not lost
         flag_o <= (flag_o & ~clr_i) | set_i;
      end
   end

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
   parameter int unsigned NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] event_i,
   input  logic [NUM-1:0] enable_i,
   input  logic           clear_i,
   output logic [NUM-1:0] flag_o,
   output logic           summary_o
);

   if (NUM < 1) begin : g_bad_num
      $error("rtc_flag_bank: NUM must be at least 1");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_cell
      rtc_flag_cell cell_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (event_i[i]),
         .clr_i  (clear_i),
         .flag_o (flag_o[i])
      );
   end

   assign summary_o = |(flag_o & enable_i);

endmodule

// File: rtl/rtc_valid_reg.sv
module rtc_valid_reg #(
   parameter int unsigned DAY_W = 6
) (
   input  logic             clk,
   input  logic             bat_rst_n,
   input  logic             rd_hit,
   input  logic             wr_hit,
   input  logic [DAY_W-1:0] wr_day,
   output logic             valid_o,
   output logic [DAY_W-1:0] day_o
);

   if (DAY_W < 1 || DAY_W > rtc_irq_pkg::FIELD_W) begin : g_bad_day
      $error("rtc_valid_reg: DAY_W out of range");
   end

   // validity bit: only a read can set it, only battery reset clears it
   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n) begin
         valid_o <= 1'b0;
      end else if (rd_hit) begin
         valid_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n) begin
         day_o <= '0;
      end else if (wr_hit) begin
         day_o <= wr_day;
      end
   end

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned FLAG_ADDR  = 2,
   parameter int unsigned VALID_ADDR = 3,
   parameter int unsigned DAY_W      = 6
) (
   input  logic              clk,
   input  logic              main_rst_n,
   input  logic              bat_rst_n,
   input  logic              tap_edge,
   input  logic              alarm_hit,
   input  logic              update_done,
   input  logic              en_periodic,
   input  logic              en_alarm,
   input  logic              en_update,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DAY_W-1:0]  wr_data,
   output logic [7:0]        rd_data,
   output logic              irq_n
);

   import rtc_irq_pkg::*;

   localparam int unsigned         NSRC     = NUM_SRC;
   localparam logic [ADDR_W-1:0]   A_FLAG   = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0]   A_VALID  = ADDR_W'(VALID_ADDR);

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("rtc_irq_status: ADDR_W out of range");
   end
   if (FLAG_ADDR == VALID_ADDR) begin : g_bad_map
      $error("rtc_irq_status: register addresses must differ");
   end
   if (FLAG_ADDR >= (1 << ADDR_W) || VALID_ADDR >= (1 << ADDR_W)) begin : g_bad_fit
      $error("rtc_irq_status: address does not fit ADDR_W");
   end

   logic              rd_flag_hit;
   logic              rd_valid_hit;
   logic              wr_valid_hit;
   logic [NSRC-1:0]   ev_vec;
   logic [NSRC-1:0]   en_vec;
   logic [NSRC-1:0]   flag_q;
   logic              summary;
   logic              vrt_q;
   logic [DAY_W-1:0]  day_q;
   flag_byte_t        flag_byte;
   valid_byte_t       valid_byte;

   assign rd_flag_hit  = rd_stb && (rd_addr == A_FLAG);
   assign rd_valid_hit = rd_stb && (rd_addr == A_VALID);
   assign wr_valid_hit = wr_stb && (wr_addr == A_VALID);

   always_comb begin
      ev_vec          = '0;
      en_vec          = '0;
      ev_vec[SRC_PER] = tap_edge;
      ev_vec[SRC_ALM] = alarm_hit;
      ev_vec[SRC_UPD] = update_done;
      en_vec[SRC_PER] = en_periodic;
      en_vec[SRC_ALM] = en_alarm;
      en_vec[SRC_UPD] = en_update;
   end

   rtc_flag_bank #(.NUM(NSRC)) bank_i (
      .clk       (clk),
      .rst_n     (main_rst_n),
      .event_i   (ev_vec),
      .enable_i  (en_vec),
      .clear_i   (rd_flag_hit),
      .flag_o    (flag_q),
      .summary_o (summary)
   );

   rtc_valid_reg #(.DAY_W(DAY_W)) valid_i (
      .clk       (clk),
      .bat_rst_n (bat_rst_n),
      .rd_hit    (rd_valid_hit),
      .wr_hit    (wr_valid_hit),
      .wr_day    (wr_data),
      .valid_o   (vrt_q),
      .day_o     (day_q)
   );

   always_comb begin
      flag_byte.summary = summary;
      flag_byte.per     = flag_q[SRC_PER];
      flag_byte.alm     = flag_q[SRC_ALM];
      flag_byte.upd     = flag_q[SRC_UPD];
      flag_byte.zero    = '0;
      valid_byte.valid  = vrt_q;
      valid_byte.zero   = 1'b0;
      valid_byte.day    = FIELD_W'(day_q);
   end

   always_comb begin
      if (rd_flag_hit) begin
         rd_data = flag_byte;
      end else if (rd_valid_hit) begin
         rd_data = valid_byte;
      end else begin
         rd_data = '0;
      end
   end

   assign irq_n = ~summary;

endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk #(
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned FLAG_ADDR  = 2,
   parameter int unsigned VALID_ADDR = 3
) (
   input logic              clk,
   input logic              main_rst_n,
   input logic              bat_rst_n,
   input logic              tap_edge,
   input logic              alarm_hit,
   input logic              update_done,
   input logic              en_periodic,
   input logic              en_alarm,
   input logic              en_update,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        rd_data,
   input logic              irq_n,
   input logic [2:0]        flag_q,
   input logic              vrt_q
);

   logic rd_f;
   logic rd_v;
   assign rd_f = rd_stb && (rd_addr == ADDR_W'(FLAG_ADDR));
   assign rd_v = rd_stb && (rd_addr == ADDR_W'(VALID_ADDR));

   p_summary_r1: assert property (@(posedge clk) disable iff (!main_rst_n)
      rd_f |-> (rd_data[7] == |(rd_data[6:4] & {en_periodic, en_alarm, en_update})));

   p_pin_r2: assert property (@(posedge clk) disable iff (!main_rst_n)
      rd_f |-> (irq_n == !rd_data[7]));

   p_set_r3: assert property (@(posedge clk) disable iff (!main_rst_n)
      tap_edge |=> flag_q[0]);

   p_clear_r4: assert property (@(posedge clk) disable iff (!main_rst_n)
      (rd_f && !tap_edge && !alarm_hit && !update_done) |=> (flag_q == 3'b000 && irq_n));

   p_keep_r5: assert property (@(posedge clk) disable iff (!main_rst_n)
      (rd_f && alarm_hit) |=> flag_q[1]);

   p_low_zero_r6: assert property (@(posedge clk) disable iff (!main_rst_n)
      rd_f |-> (rd_data[3:0] == 4'h0));

   p_vrt_set_r8: assert property (@(posedge clk) disable iff (!bat_rst_n)
      rd_v |=> vrt_q);

   p_vrt_hold_r8: assert property (@(posedge clk) disable iff (!bat_rst_n)
      vrt_q |=> vrt_q);

   p_bit6_r9: assert property (@(posedge clk) disable iff (!bat_rst_n)
      rd_v |-> (rd_data[6] == 1'b0));

   p_idle_r11: assert property (@(posedge clk) disable iff (!main_rst_n)
      !rd_stb |-> (rd_data == 8'h00));

endmodule

bind rtc_irq_status rtc_irq_status_chk #(
   .ADDR_W     (ADDR_W),
   .FLAG_ADDR  (FLAG_ADDR),
   .VALID_ADDR (VALID_ADDR)
) chk_i (
   .clk         (clk),
   .main_rst_n  (main_rst_n),
   .bat_rst_n   (bat_rst_n),
   .tap_edge    (tap_edge),
   .alarm_hit   (alarm_hit),
   .update_done (update_done),
   .en_periodic (en_periodic),
   .en_alarm    (en_alarm),
   .en_update   (en_update),
   .rd_stb      (rd_stb),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .irq_n       (irq_n),
   .flag_q      (flag_q),
   .vrt_q       (vrt_q)
);

// File: tb/rtc_irq_status_tb.sv
module rtc_irq_status_tb_top;

   localparam logic [1:0] A_FLAG  = 2'd2;
   localparam logic [1:0] A_VALID = 2'd3;

   logic       clk = 1'b0;
   logic       main_rst_n = 1'b0;
   logic       bat_rst_n = 1'b0;
   logic       tap_edge = 1'b0, alarm_hit = 1'b0, update_done = 1'b0;
   logic       en_periodic = 1'b0, en_alarm = 1'b0, en_update = 1'b0;
   logic       rd_stb = 1'b0, wr_stb = 1'b0;
   logic [1:0] rd_addr = 2'd0, wr_addr = 2'd0;
   logic [5:0] wr_data = 6'd0;
   logic [7:0] rd_data;
   logic       irq_n;

   int unsigned n_checks = 0;
   int unsigned n_fails  = 0;

   // bench model: index 0 periodic, 1 alarm, 2 update
   logic [2:0] m_flags = 3'b000;
   logic       m_vrt   = 1'b0;
   logic [5:0] m_day   = 6'd0;

   always #10 clk = ~clk;

   rtc_irq_status dut_i (
      .clk(clk), .main_rst_n(main_rst_n), .bat_rst_n(bat_rst_n),
      .tap_edge(tap_edge), .alarm_hit(alarm_hit), .update_done(update_done),
      .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
   );

   function automatic logic exp_sum();
      return |(m_flags & {en_update, en_alarm, en_periodic});
   endfunction

   function automatic logic [7:0] exp_rd();
      if (!rd_stb) return 8'h00;
      if (rd_addr == A_FLAG)
         return {exp_sum(), m_flags[0], m_flags[1], m_flags[2], 4'h0};
      if (rd_addr == A_VALID)
         return {m_vrt, 1'b0, m_day};
      return 8'h00;
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at falling edge, check before rising edge, update model after it
   task automatic step(input logic t, input logic a, input logic u,
                       input logic ep, input logic ea, input logic eu,
                       input logic rs, input logic [1:0] ra,
                       input logic ws, input logic [1:0] wa, input logic [5:0] wd,
                       input string tag);
      logic [2:0] ev;
      @(negedge clk);
      tap_edge = t; alarm_hit = a; update_done = u;
      en_periodic = ep; en_alarm = ea; en_update = eu;
      rd_stb = rs; rd_addr = ra; wr_stb = ws; wr_addr = wa; wr_data = wd;
      #2;
      check8("R2", {7'd0, irq_n}, {7'd0, ~exp_sum()});
      check8(tag, rd_data, exp_rd());
      ev = {u, a, t};
      @(posedge clk);
      if (rs && ra == A_FLAG) m_flags = ev;
      else                    m_flags = m_flags | ev;
      if (rs && ra == A_VALID) m_vrt = 1'b1;
      if (ws && wa == A_VALID) m_day = wd;
   endtask

   task automatic idle_inputs();
      tap_edge = 0; alarm_hit = 0; update_done = 0;
      rd_stb = 0; wr_stb = 0;
   endtask

   initial begin
      #(200000 * 20);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      // both resets, from time zero
      repeat (3) @(negedge clk);
      #2;
      check8("R7", {7'd0, irq_n}, 8'h01);
      @(negedge clk);
      main_rst_n = 1'b1; bat_rst_n = 1'b1;

      step(0,0,0, 0,0,0, 1,A_FLAG,  0,0,0, "R7");
      step(0,0,0, 0,0,0, 1,A_VALID, 0,0,0, "R10");
      step(0,0,0, 0,0,0, 1,A_VALID, 0,0,0, "R8");   // returns set validity bit

      // flag set with enable off: no interrupt, summary 0
      step(0,1,0, 0,0,0, 0,0, 0,0,0, "R11");
      step(0,0,0, 0,0,0, 1,A_FLAG, 0,0,0, "R3");    // 0x20
      step(0,1,0, 0,0,0, 0,0, 0,0,0, "R11");
      step(0,0,0, 0,1,0, 1,A_FLAG, 0,0,0, "R1");    // 0xA0
      step(0,0,0, 0,1,0, 0,0, 0,0,0, "R4");         // irq_n back to 1

      // event coinciding with a clearing read
      step(0,0,1, 1,0,0, 0,0, 0,0,0, "R11");
      step(1,0,0, 1,0,0, 1,A_FLAG, 0,0,0, "R4");    // 0x10
      step(0,0,0, 1,0,0, 1,A_FLAG, 0,0,0, "R5");    // 0xC0

      // write to the flag address is ignored
      step(0,0,1, 0,0,1, 0,0, 0,0,0, "R11");
      step(0,0,0, 0,0,1, 0,0, 1,A_FLAG,6'h00, "R6");
      step(0,0,0, 0,0,1, 1,A_FLAG, 0,0,0, "R6");    // 0x90

      // day field write
      step(0,0,0, 0,0,0, 0,0, 1,A_VALID,6'h3F, "R11");
      step(0,0,0, 0,0,0, 1,A_VALID, 0,0,0, "R9");   // 0xBF

      // main reset keeps validity state
      step(1,1,1, 1,1,1, 0,0, 0,0,0, "R11");
      @(negedge clk);
      idle_inputs();
      main_rst_n = 1'b0;
      #2;
      check8("R7", {7'd0, irq_n}, 8'h01);
      m_flags = 3'b000;
      @(negedge clk);
      main_rst_n = 1'b1;
      step(0,0,0, 1,1,1, 1,A_FLAG,  0,0,0, "R7");
      step(0,0,0, 1,1,1, 1,A_VALID, 0,0,0, "R7");

      // constrained random traffic, fixed seed
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] ra;
         logic       rs;
         string      tg;
         rs = ($urandom_range(0, 3) == 0);
         ra = 2'($urandom_range(0, 3));
         if (!rs)                tg = "R11";
         else if (ra == A_FLAG)  tg = "R4";
         else if (ra == A_VALID) tg = "R8";
         else                    tg = "R11";
         step(($urandom_range(0, 9) == 0), ($urandom_range(0, 15) == 0),
              ($urandom_range(0, 11) == 0),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              rs, ra,
              ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)),
              tg);
      end

      // battery reset clears validity bit and day field
      @(negedge clk);
      idle_inputs();
      bat_rst_n = 1'b0;
      m_vrt = 1'b0; m_day = 6'd0;
      @(negedge clk);
      bat_rst_n = 1'b1;
      step(0,0,0, 0,0,0, 1,A_VALID, 0,0,0, "R10");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule